// File: doc/BRIEF.md
# Eight-Port Omega Switch Fabric

This block is a circuit-switched interconnect that joins eight sources to eight sinks through three ranks of 2x2 switching elements, with a perfect-shuffle wiring ahead of each rank. Every source offers at most one word per cycle. The word carries a 3-bit sink address. Each element on the route is set to pass straight or to swap. The setting is the XOR of the source and sink address bits that belong to that rank.

Only one route exists between any source and sink, so two requests can need the same element output in the same cycle. The block detects this collision combinationally and accepts the lower-numbered source. The other source sees no grant. It keeps its request raised and competes again in the next cycle. An accepted word leaves the fabric through a register, one cycle after its grant, on the sink port it named.

Top module: `omega_fabric`

## Requirements
- R1: While `rst` is high, every bit of `in_grant_o` is 0. After a clock edge with `rst` high, every bit of `out_valid_o` and `out_data_o` is 0.
- R2: A source is granted only in a cycle in which its `in_valid_i` bit is high.
- R3: If source i is granted in cycle t, then in cycle t+1 the output lane equal to its destination has `out_valid_o` high and carries source i's data word from cycle t.
- R4: The number of high `out_valid_o` bits in cycle t+1 equals the number of grants in cycle t. A lane that receives no word in a cycle shows `out_valid_o` 0 and data 0 in the next cycle.
- R5: Whenever at least one request is valid, at least one is granted. A valid request on source 0 is always granted.
- R6: A request from source s=s2s1s0 to sink d=d2d1d0 occupies these element output lines: {s1,s0,d2} after the first rank, {s0,d2,d1} after the second rank, and d after the last rank. Two requests that share any of these lines are never granted in the same cycle, and the lower-numbered source wins.
- R7: A valid request is granted exactly when it shares no line with a request granted from a lower-numbered source. Ungranted lower requests do not block it.
- R8: If the eight sources hold a full permutation of sinks and each source drops its request once granted, all eight transfers are granted within eight cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 8 | Request valid, one bit per source |
| in_dest_i | input | 8x3 | Sink address per source |
| in_data_i | input | 8xDATA_W | Data word per source |
| in_grant_o | output | 8 | Combinational grant, one bit per source, same cycle as the request |
| out_valid_o | output | 8 | Registered word-present flag per sink |
| out_data_o | output | 8xDATA_W | Registered data word per sink, zero when not valid |

## Verification
Every cycle, the assertions check four things. A grant is followed by its word at the named sink with the data intact. The count of words leaving matches the count of grants. A grant never appears without a request. The lowest request always gets through. Only the bench scenarios can show which of two colliding requests wins and which route lines count as a collision. The same holds for whether a blocked request delays unrelated higher sources, and whether a held permutation fully drains. These scenarios include the shared-first-rank case, the same-sink case, the identity pattern and random permutations.

// File: rtl/omega_pkg.sv
package omega_pkg;

    localparam int unsigned PORTS  = 8;
    localparam int unsigned ADDR_W = $clog2(PORTS);
    localparam int unsigned STAGES = ADDR_W;
    localparam int unsigned ELEMS  = PORTS / 2;

    typedef logic [ADDR_W-1:0] addr_t;

    // Route of one request: the line it leaves each rank on, and each element setting.
    typedef struct packed {
        addr_t [STAGES-1:0] exit_line;
        logic  [STAGES-1:0] swap;
    } route_t;

    // Perfect shuffle: rotate the port index left by one.
    function automatic addr_t shuffle(addr_t x);
        return {x[ADDR_W-2:0], x[ADDR_W-1]};
    endfunction

    // Rank k resolves address bit ADDR_W-1-k (the most significant bit first).
    function automatic route_t plan_route(addr_t src, addr_t dst);
        route_t r;
        addr_t  ln;
        ln = src;
        for (int k = 0; k < STAGES; k++) begin
            ln             = {ln[ADDR_W-2:0], dst[ADDR_W-1-k]};
            r.exit_line[k] = ln;
            r.swap[k]      = src[ADDR_W-1-k] ^ dst[ADDR_W-1-k];
        end
        return r;
    endfunction

endpackage

// File: rtl/omega_element.sv
module omega_element #(
    parameter int unsigned DATA_W = 16
) (
    input  logic                   swap_i,
    input  logic [1:0]             vld_i,
    input  logic [1:0][DATA_W-1:0] dat_i,
    output logic [1:0]             vld_o,
    output logic [1:0][DATA_W-1:0] dat_o
);

    always_comb begin
        if (swap_i) begin
            vld_o = {vld_i[0], vld_i[1]};
            dat_o = {dat_i[0], dat_i[1]};
        end else begin
            vld_o = vld_i;
            dat_o = dat_i;
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [ELEMS-1:0]             swap_i,
    input  logic [PORTS-1:0]             vld_i,
    input  logic [PORTS-1:0][DATA_W-1:0] dat_i,
    output logic [PORTS-1:0]             vld_o,
    output logic [PORTS-1:0][DATA_W-1:0] dat_o
);

    logic [PORTS-1:0]             sh_vld;
    logic [PORTS-1:0][DATA_W-1:0] sh_dat;

    // Shuffle wiring ahead of the rank.
    for (genvar i = 0; i < PORTS; i++) begin : g_shuffle
        localparam int unsigned DST = int'(shuffle(addr_t'(i)));
        assign sh_vld[DST] = vld_i[i];
        assign sh_dat[DST] = dat_i[i];
    end

    for (genvar j = 0; j < ELEMS; j++) begin : g_elem
        omega_element #(.DATA_W(DATA_W)) u_elem (
            .swap_i (swap_i[j]),
            .vld_i  (sh_vld[2*j+1:2*j]),
            .dat_i  (sh_dat[2*j+1:2*j]),
            .vld_o  (vld_o[2*j+1:2*j]),
            .dat_o  (dat_o[2*j+1:2*j])
        );
    end

endmodule

// File: rtl/omega_arbiter.sv
module omega_arbiter
    import omega_pkg::*;
(
    input  logic                           en_i,
    input  logic [PORTS-1:0]               req_vld_i,
    input  logic [PORTS-1:0][ADDR_W-1:0]   req_dst_i,
    output logic [PORTS-1:0]               grant_o,
    output logic [STAGES-1:0][ELEMS-1:0]   swap_o
);

    route_t                       route [PORTS];
    logic [STAGES-1:0][PORTS-1:0] busy;
    logic                         hit;

    for (genvar i = 0; i < PORTS; i++) begin : g_route
        assign route[i] = plan_route(addr_t'(i), req_dst_i[i]);
    end

    // Lower source index first: a request is taken when none of its lines is busy.
    always_comb begin
        busy    = '0;
        grant_o = '0;
        swap_o  = '0;
        hit     = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            hit = 1'b0;
            for (int k = 0; k < STAGES; k++) begin
                hit = hit | busy[k][route[i].exit_line[k]];
            end
            if (en_i && req_vld_i[i] && !hit) begin
                grant_o[i] = 1'b1;
                for (int k = 0; k < STAGES; k++) begin
                    busy[k][route[i].exit_line[k]] = 1'b1;
                    swap_o[k][route[i].exit_line[k][ADDR_W-1:1]] = route[i].swap[k];
                end
            end
        end
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PORTS-1:0]               in_valid_i,
    input  logic [PORTS-1:0][ADDR_W-1:0]   in_dest_i,
    input  logic [PORTS-1:0][DATA_W-1:0]   in_data_i,
    output logic [PORTS-1:0]               in_grant_o,
    output logic [PORTS-1:0]               out_valid_o,
    output logic [PORTS-1:0][DATA_W-1:0]   out_data_o
);

    logic [STAGES-1:0][ELEMS-1:0] swap;
    logic [PORTS-1:0]             vld_chain [STAGES+1];
    logic [PORTS-1:0][DATA_W-1:0] dat_chain [STAGES+1];

    omega_arbiter u_arb (
        .en_i      (!rst),
        .req_vld_i (in_valid_i),
        .req_dst_i (in_dest_i),
        .grant_o   (in_grant_o),
        .swap_o    (swap)
    );

    assign vld_chain[0] = in_grant_o;
    for (genvar i = 0; i < PORTS; i++) begin : g_gate
        assign dat_chain[0][i] = in_grant_o[i] ? in_data_i[i] : '0;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_rank
        omega_stage #(.DATA_W(DATA_W)) u_stage (
            .swap_i (swap[s]),
            .vld_i  (vld_chain[s]),
            .dat_i  (dat_chain[s]),
            .vld_o  (vld_chain[s+1]),
            .dat_o  (dat_chain[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= '0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= vld_chain[STAGES];
            out_data_o  <= dat_chain[STAGES];
        end
    end

    // R2: no grant without a request
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        (in_grant_o & ~in_valid_i) == '0);

    // R4: words out match grants one cycle earlier
    a_r4_count_kept: assert property (@(posedge clk) disable iff (rst)
        $countones(out_valid_o) == $countones($past(in_grant_o)));

    // R5: progress and top priority
    a_r5_some_grant: assert property (@(posedge clk) disable iff (rst)
        (|in_valid_i) |-> (|in_grant_o));
    a_r5_src0_wins: assert property (@(posedge clk) disable iff (rst)
        in_valid_i[0] |-> in_grant_o[0]);

    // R3: each granted word reaches its sink intact
    for (genvar i = 0; i < PORTS; i++) begin : g_chk
        a_r3_delivered: assert property (@(posedge clk) disable iff (rst)
            in_grant_o[i] |=> (out_valid_o[$past(in_dest_i[i])] &&
                               out_data_o[$past(in_dest_i[i])] == $past(in_data_i[i])));
    end

endmodule

// File: tb/omega_fabric_bench.sv
module omega_fabric_bench;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [7:0]            in_valid = '0;
    logic [7:0][2:0]       in_dest = '0;
    logic [7:0][15:0]      in_data = '0;
    logic [7:0]            grant;
    logic [7:0]            out_valid;
    logic [7:0][15:0]      out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]       v;
    logic [7:0][2:0]  d;
    logic [7:0][15:0] dt;
    logic [7:0]       last_grant;

    always #2 clk = ~clk;

    omega_fabric #(.DATA_W(16)) u_omega_fabric (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .in_dest_i   (in_dest),
        .in_data_i   (in_data),
        .in_grant_o  (grant),
        .out_valid_o (out_valid),
        .out_data_o  (out_data)
    );

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Line used after rank k, per R6.
    function automatic logic [2:0] hop(logic [2:0] s, logic [2:0] t, int k);
        case (k)
            0:       return {s[1], s[0], t[2]};
            1:       return {s[0], t[2], t[1]};
            default: return t;
        endcase
    endfunction

    function automatic logic [7:0] model_grant(logic [7:0] vv, logic [7:0][2:0] dd);
        logic [7:0] used [3];
        logic [7:0] g;
        bit clash;
        g = '0;
        for (int k = 0; k < 3; k++) used[k] = '0;
        for (int i = 0; i < 8; i++) begin
            clash = 1'b0;
            for (int k = 0; k < 3; k++)
                if (used[k][hop(3'(i), dd[i], k)]) clash = 1'b1;
            if (vv[i] && !clash) begin
                g[i] = 1'b1;
                for (int k = 0; k < 3; k++) used[k][hop(3'(i), dd[i], k)] = 1'b1;
            end
        end
        return g;
    endfunction

    task automatic step(input string gtag);
        logic [7:0]       eg;
        logic [7:0]       ev;
        logic [7:0][15:0] ed;
        @(negedge clk);
        in_valid = v; in_dest = d; in_data = dt;
        #1;
        eg = model_grant(v, d);
        chk(grant == eg, {gtag, " grant pattern"}, 128'(grant), 128'(eg));
        last_grant = grant;
        ev = '0; ed = '0;
        for (int i = 0; i < 8; i++)
            if (eg[i]) begin
                ev[d[i]] = 1'b1;
                ed[d[i]] = dt[i];
            end
        @(posedge clk);
        #1;
        chk(out_valid == ev, "R3 R4 output valid", 128'(out_valid), 128'(ev));
        chk(out_data == ed, "R3 R4 output data", 128'(out_data), 128'(ed));
    endtask

    task automatic rand_data();
        for (int i = 0; i < 8; i++) dt[i] = 16'($urandom);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        logic [7:0]      pending;
        logic [7:0][2:0] perm;
        logic [2:0]      tmp;
        int              j;
        void'($urandom(32'd5150));
        v = '0; d = '0; dt = '0; last_grant = '0;

        // R1: reset holds grants and outputs at zero
        repeat (2) @(posedge clk);
        @(negedge clk);
        in_valid = 8'hFF;
        for (int i = 0; i < 8; i++) in_dest[i] = 3'(i);
        #1;
        chk(grant == 8'h00, "R1 grant in reset", 128'(grant), 0);
        @(posedge clk); #1;
        chk(out_valid == 8'h00, "R1 out valid in reset", 128'(out_valid), 0);
        chk(out_data == '0, "R1 out data in reset", 128'(out_data), 0);
        @(negedge clk);
        rst = 1'b0; in_valid = '0;

        // R7: identity pattern, no collisions
        v = 8'hFF; rand_data();
        for (int i = 0; i < 8; i++) d[i] = 3'(i);
        step("R7");
        chk(last_grant == 8'hFF, "R7 identity all granted", 128'(last_grant), 128'(8'hFF));

        // R6: 2->6 and 6->4 share the first-rank line; 7->7 is clear
        v = 8'h00; d = '0; rand_data();
        v[2] = 1'b1; d[2] = 3'd6;
        v[6] = 1'b1; d[6] = 3'd4;
        v[7] = 1'b1; d[7] = 3'd7;
        step("R6");
        chk(last_grant == 8'h84, "R6 collision lower wins", 128'(last_grant), 128'(8'h84));
        v[2] = 1'b0; v[7] = 1'b0; rand_data();
        step("R6");
        chk(last_grant == 8'h40, "R6 blocked source retried", 128'(last_grant), 128'(8'h40));

        // R6: two sources to one sink
        v = 8'h28; d = '0; d[3] = 3'd7; d[5] = 3'd7; rand_data();
        step("R6");
        chk(last_grant == 8'h08, "R6 same sink", 128'(last_grant), 128'(8'h08));

        // R5: single high source alone
        v = 8'h80; d = '0; d[7] = 3'd0; rand_data();
        step("R5");
        chk(last_grant == 8'h80, "R5 lone request", 128'(last_grant), 128'(8'h80));

        // R4: idle cycle gives empty outputs
        v = 8'h00; rand_data();
        step("R4");

        // R8: random permutations drain within eight cycles
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 8; i++) perm[i] = 3'(i);
            for (int i = 7; i > 0; i--) begin
                j = int'($urandom % (i + 1));
                tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
            end
            pending = 8'hFF;
            for (int c = 0; c < 8 && pending != 8'h00; c++) begin
                v = pending; d = perm; rand_data();
                step("R7");
                pending = pending & ~last_grant;
            end
            chk(pending == 8'h00, "R8 permutation drained", 128'(pending), 0);
        end

        // R7: random requests
        for (int t = 0; t < 300; t++) begin
            v = 8'($urandom);
            for (int i = 0; i < 8; i++) d[i] = 3'($urandom);
            rand_data();
            step("R7");
        end

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        summary();
    end

endmodule